// File: doc/BRIEF.md
# One-time-programmable byte write controller

This block runs the write sequence of a small add-only memory whose cells can only go from 1 to 0. A bus master hands it a byte stream: a write command, a low and a high address byte, then a data byte. The block answers with a CRC8 over what it received, so the master can compare that CRC with its own before it commits. It then waits for a programming strobe, which stands in for the high-voltage pulse. On that strobe it clears, in the addressed byte, every bit that is 0 in the data. It then returns the stored byte so the master can check the result.

When the stored byte shows the requested zeros, the address advances by itself and the master may send the next data byte at once. Addresses beyond the array are cut down to the array's width. The CRC is computed from the cut-down address, so a master that sent an out-of-range address sees a mismatch. Reset abandons the sequence at any step. The memory contents persist across reset.

Top module: `otp_write_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid` is 0 and the controller waits for a command byte. Reset does not change the memory contents.
- R2: The write sequence begins with command byte 0x0F. The low address byte, the high address byte and one data byte follow, each accepted on a cycle with `in_valid` high. Any other command byte makes the block ignore all input and produce no output until reset.
- R3: One cycle after the data byte is accepted, `out_valid` pulses for one cycle with `out_byte` holding a CRC8. The CRC8 uses x^8+x^5+x^4+1, takes bits LSB first and starts from 0. It covers the command byte, the effective low address byte, the effective high address byte and the data byte, in that order.
- R4: The effective address keeps only the low 7 bits of the 16-bit address and forces the nine upper bits to 0, so the effective high byte is always 0x00. The CRC and the write both use this effective address.
- R5: Every memory byte starts erased at 0xFF.
- R6: A programming strobe while the controller waits for it sets the addressed byte to its old value ANDed with the data byte.
- R7: Three cycles after the strobe is sampled, `out_valid` pulses with `out_byte` equal to the stored byte. Bit 0 of `out_byte` is the first bit in serial order.
- R8: If every 0 bit of the data is also 0 in the stored byte, the address increments, wrapping from 0x7F to 0x00. The next data byte is then accepted directly, without a new command or address. Its CRC covers the new effective low address byte, 0x00 and the data byte, starting from 0.
- R9: A programming strobe in any other state writes nothing and produces no output.
- R10: A reset in the middle of a sequence leaves the memory unwritten when no strobe has been accepted.
- R11: Bytes that arrive while the controller waits for the strobe, programs or verifies are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte from the master is present on `in_byte` |
| in_byte | input | 8 | Byte from the master |
| prog_strobe | input | 1 | Programming pulse, one cycle |
| out_valid | output | 1 | One-cycle pulse: `out_byte` holds a CRC or a verify byte |
| out_byte | output | 8 | CRC8 or stored byte returned to the master |

## Verification
The hardest situations to reach are these:
- a second write to a byte that is already partly programmed;
- the wrap of the auto-incremented address from the top byte back to zero.

Both depend on memory that persists through reset. The stimulus therefore programs an address, resets, and writes the same address again, so the verify byte has to show the AND of both data values. The bench also starts a sequence at the top address and follows it with a direct data byte, and checks the CRC of the wrapped address 0x00. Strobes placed in the address phase and after a verify, together with stray bytes during the wait, are shown to be harmless by later verify bytes.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    S_CMD  = 3'd0,
    S_LO   = 3'd1,
    S_HI   = 3'd2,
    S_DATA = 3'd3,
    S_WAIT = 3'd4,
    S_PROG = 3'd5,
    S_VER  = 3'd6,
    S_HOLD = 3'd7
  } otp_state_e;

  // One byte through a reflected CRC8, bit 0 first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                           input logic [7:0] din,
                                           input logic [7:0] poly_rev);
    logic [7:0] c;
    logic       fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ poly_rev;
    end
    return c;
  endfunction

endpackage

// File: rtl/otp_crc_unit.sv
module otp_crc_unit #(
  parameter logic [7:0] POLY_REV = 8'h8C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       seed_en,
  input  logic [7:0] seed,
  input  logic       step_en,
  input  logic [7:0] din,
  output logic [7:0] crc_nxt
);
  logic [7:0] crc_q;

  assign crc_nxt = otp_pkg::crc8_step(crc_q, din, POLY_REV);

  always_ff @(posedge clk) begin
    if (rst)          crc_q <= '0;
    else if (seed_en) crc_q <= seed;
    else if (step_en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/otp_addr_ctr.sv
module otp_addr_ctr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] addr_nxt
);
  assign addr_nxt = addr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (inc)  addr_q <= addr_nxt;
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/otp_write_ctrl.sv
module otp_write_ctrl #(
  parameter int         DEPTH    = 128,
  parameter logic [7:0] WR_CMD   = 8'h0F,
  parameter logic [7:0] POLY_REV = 8'h8C,
  localparam int        AW       = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       prog_strobe,
  output logic       out_valid,
  output logic [7:0] out_byte
);
  import otp_pkg::*;

  otp_state_e    state_q;
  logic [7:0]    data_q;
  logic [7:0]    rd_q;
  logic [AW-1:0] addr_q, addr_nxt;
  logic [7:0]    lo_eff, nxt_lo, crc_din, crc_nxt, crc_seed;
  logic          crc_seed_en, crc_step_en, addr_load, addr_inc, mem_we;
  logic          verify_ok;

  assign lo_eff    = 8'(in_byte[AW-1:0]);
  assign nxt_lo    = 8'(addr_nxt);
  assign verify_ok = ((rd_q & ~data_q) == 8'h00);
  assign mem_we    = (state_q == S_WAIT) && prog_strobe;

  always_comb begin
    crc_seed_en = 1'b0;
    crc_seed    = 8'h00;
    crc_step_en = 1'b0;
    addr_load   = 1'b0;
    addr_inc    = 1'b0;
    case (state_q)
      S_LO:    crc_din = lo_eff;
      S_HI:    crc_din = 8'h00;
      default: crc_din = in_byte;
    endcase
    case (state_q)
      S_CMD: if (in_valid && in_byte == WR_CMD) begin
        crc_seed_en = 1'b1;
        crc_seed    = crc8_step(8'h00, in_byte, POLY_REV);
      end
      S_LO:   if (in_valid) begin
        crc_step_en = 1'b1;
        addr_load   = 1'b1;
      end
      S_HI, S_DATA: crc_step_en = in_valid;
      S_VER: if (verify_ok) begin
        addr_inc    = 1'b1;
        crc_seed_en = 1'b1;
        crc_seed    = crc8_step(crc8_step(8'h00, nxt_lo, POLY_REV), 8'h00, POLY_REV);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_CMD;
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
      data_q    <= 8'hFF;
    end else begin
      out_valid <= 1'b0;
      case (state_q)
        S_CMD:  if (in_valid) state_q <= (in_byte == WR_CMD) ? S_LO : S_HOLD;
        S_LO:   if (in_valid) state_q <= S_HI;
        S_HI:   if (in_valid) state_q <= S_DATA;
        S_DATA: if (in_valid) begin
          data_q    <= in_byte;
          out_byte  <= crc_nxt;
          out_valid <= 1'b1;
          state_q   <= S_WAIT;
        end
        S_WAIT: if (prog_strobe) state_q <= S_PROG;
        S_PROG: state_q <= S_VER;
        S_VER: begin
          out_byte  <= rd_q;
          out_valid <= 1'b1;
          state_q   <= verify_ok ? S_DATA : S_HOLD;
        end
        default: state_q <= S_HOLD;
      endcase
    end
  end

  otp_crc_unit #(.POLY_REV(POLY_REV)) u_crc (
    .clk(clk), .rst(rst), .seed_en(crc_seed_en), .seed(crc_seed),
    .step_en(crc_step_en), .din(crc_din), .crc_nxt(crc_nxt)
  );

  otp_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(addr_load), .load_val(in_byte[AW-1:0]),
    .inc(addr_inc), .addr_q(addr_q), .addr_nxt(addr_nxt)
  );

  otp_cell_array #(.DEPTH(DEPTH), .DW(8), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(rd_q & data_q),
    .raddr(addr_q), .rdata_q(rd_q)
  );
endmodule

// File: rtl/otp_write_ctrl_chk.sv
module otp_write_ctrl_chk #(
  parameter int AW = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               prog_strobe,
  input logic               out_valid,
  input otp_pkg::otp_state_e state_q,
  input logic [AW-1:0]      addr_q,
  input logic [7:0]         rd_q,
  input logic [7:0]         data_q
);
  import otp_pkg::*;

  // R1: reset leaves the output idle and the controller awaiting a command
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && state_q == S_CMD));

  // R3: the CRC follows the data byte by one cycle
  p_crc_after_data_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DATA && in_valid) |=> out_valid);

  // R3, R7: every output is a single-cycle pulse
  p_out_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: the verified byte carries every zero of the data
  p_and_result_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_VER) |-> ((rd_q & ~data_q) == 8'h00));

  // R8: a passed verify moves to the next address
  p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_VER) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

  // R9: a strobe outside the wait state does not move an idle-input controller
  p_strobe_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (prog_strobe && !in_valid &&
     (state_q == S_CMD || state_q == S_LO || state_q == S_HI ||
      state_q == S_DATA || state_q == S_HOLD)) |=> $stable(state_q));

  // R11: without a strobe the wait state holds whatever bytes arrive
  p_wait_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT && !prog_strobe) |=> (state_q == S_WAIT && !out_valid));
endmodule

bind otp_write_ctrl otp_write_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .prog_strobe(prog_strobe),
  .out_valid(out_valid), .state_q(state_q), .addr_q(addr_q),
  .rd_q(rd_q), .data_q(data_q)
);

// File: tb/test_otp_write_ctrl.sv
`timescale 1ns/1ps
module test_otp_write_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       prog_strobe = 1'b0;
  logic       out_valid;
  logic [7:0] out_byte;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  otp_write_ctrl i_otp_write_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .prog_strobe(prog_strobe), .out_valid(out_valid), .out_byte(out_byte)
  );

  // Serial CRC: shift register of x^8+x^5+x^4+1, message bit 0 first.
  function automatic logic [7:0] ref_crc(input logic [31:0] msg, input int nbytes);
    logic [7:0] r = 8'h00;
    for (int k = 0; k < nbytes * 8; k++) begin
      logic m;
      m = r[0] ^ msg[k];
      r = {m, r[7:1]};
      r[3] = r[3] ^ m;
      r[2] = r[2] ^ m;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) begin in_valid = 1'b1; in_byte = b; end
    @(negedge clk) in_valid = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk) prog_strobe = 1'b1;
    @(negedge clk) prog_strobe = 1'b0;
  endtask

  task automatic expect_out(input logic [7:0] exp, input string req);
    for (int i = 0; i < 8; i++) begin
      if (out_valid) break;
      @(negedge clk);
    end
    check(out_valid && out_byte == exp, req, out_valid ? out_byte : 8'hXX, exp);
    @(negedge clk);
  endtask

  task automatic expect_none(input int cycles, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      if (out_valid) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, req, {7'd0, seen}, 8'h00);
  endtask

  // Full header plus data; checks the CRC over the effective address.
  task automatic start_write(input logic [15:0] a, input logic [7:0] d, input string req);
    logic [7:0] lo_e;
    lo_e = {1'b0, a[6:0]};
    send_byte(8'h0F);
    send_byte(a[7:0]);
    send_byte(a[15:8]);
    send_byte(d);
    expect_out(ref_crc({d, 8'h00, lo_e, 8'h0F}, 4), req);
  endtask

  task automatic next_data(input logic [6:0] a, input logic [7:0] d, input string req);
    send_byte(d);
    expect_out(ref_crc({8'h00, d, 8'h00, 1'b0, a}, 3), req);
  endtask

  task automatic t_reset();
    do_reset();
    check(!out_valid, "R1 reset idle", {7'd0, out_valid}, 8'h00);
  endtask

  task automatic t_basic();
    start_write(16'h0005, 8'hA5, "R2 R3 crc basic");
    expect_none(6, "R11 wait for strobe");
    strobe();
    expect_out(8'hA5, "R5 R6 R7 verify basic");
    next_data(7'h06, 8'h3C, "R8 crc after increment");
    strobe();
    expect_out(8'h3C, "R8 verify incremented");
  endtask

  task automatic t_and_accum();
    do_reset();
    start_write(16'h0005, 8'h0F, "R3 crc rewrite");
    strobe();
    expect_out(8'h05, "R6 AND accumulation");
  endtask

  task automatic t_truncate();
    do_reset();
    start_write(16'h1285, 8'hFF, "R4 crc truncated addr");
    strobe();
    expect_out(8'h05, "R4 truncated write target");
    next_data(7'h06, 8'hFF, "R4 R8 crc after truncation");
    strobe();
    expect_out(8'h3C, "R8 verify 0x06 kept");
  endtask

  task automatic t_wrap();
    do_reset();
    start_write(16'h007F, 8'h11, "R3 crc top addr");
    strobe();
    expect_out(8'h11, "R7 verify top addr");
    strobe();
    expect_none(6, "R9 strobe after verify");
    next_data(7'h00, 8'h22, "R8 crc wrap to 0x00");
    strobe();
    expect_out(8'h22, "R8 verify wrapped");
  endtask

  task automatic t_stray_strobe();
    do_reset();
    strobe();
    send_byte(8'h0F);
    strobe();
    send_byte(8'h10);
    strobe();
    send_byte(8'h00);
    strobe();
    expect_none(4, "R9 strobes in header");
    send_byte(8'hF0);
    expect_out(ref_crc({8'hF0, 8'h00, 8'h10, 8'h0F}, 4), "R9 crc after stray strobes");
    send_byte(8'h00);
    expect_none(4, "R11 stray byte in wait");
    strobe();
    expect_out(8'hF0, "R9 R11 verify unaffected");
  endtask

  task automatic t_abandon();
    do_reset();
    start_write(16'h0020, 8'h00, "R3 crc before abandon");
    do_reset();
    start_write(16'h0020, 8'hFF, "R10 crc restart");
    strobe();
    expect_out(8'hFF, "R10 R5 byte unwritten");
  endtask

  task automatic t_bad_cmd();
    do_reset();
    send_byte(8'hAA);
    send_byte(8'h30);
    send_byte(8'h00);
    send_byte(8'h00);
    strobe();
    expect_none(8, "R2 foreign command ignored");
    do_reset();
    start_write(16'h0030, 8'hFF, "R2 crc after foreign cmd");
    strobe();
    expect_out(8'hFF, "R2 no write by foreign cmd");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_and_accum();
    t_truncate();
    t_wrap();
    t_stray_strobe();
    t_abandon();
    t_bad_cmd();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule